// File: doc/BRIEF.md
# Snapshot-Buffered Timekeeper Register File

This block is the host-side register file of a serial-bus timekeeper. A byte-level bus front end gives it strobes for bus start, bus stop, pointer load, byte read and byte write. It decodes a 5-bit register pointer over 32 addresses. The pointer steps forward after every byte transferred. The first seven addresses hold time and date. The next nine hold alarm and control bytes. The upper sixteen are general-purpose scratch bytes.

Reads of time and date never see the counters that are running. They are served from a snapshot copy. The snapshot is refreshed only at a bus start, at a bus stop, or when the pointer steps from the last address back to zero. A burst read therefore returns one coherent instant while the counter chain keeps running.

Writes to time and date are collected in a separate write buffer. At bus stop they are handed to the counter chain as one load, with a mask that marks the bytes that were written. A multi-byte time set therefore lands all at once.

Top module: `tk_regfile`

## Requirements
- R1: After reset the pointer is 00h, the snapshot, the alarm/control bytes and the scratch bytes all read as 00h, and `set_load` is low.
- R2: A `ptr_load` strobe sets the pointer to `ptr_val`, and `rd_data` always shows the byte at the current pointer. If `ptr_load` and a read or write strobe come in the same cycle, `ptr_load` wins.
- R3: Each `rd_strobe` or `wr_strobe` without `ptr_load` advances the pointer by one. It wraps from 1Fh to 00h.
- R4: Addresses 00h–06h read from the snapshot. Changes on `live_time` are not visible on reads until a refresh event occurs.
- R5: A `bus_start` strobe copies `live_time` into the snapshot at that clock edge.
- R6: A `bus_stop` strobe copies `live_time` into the snapshot at that clock edge.
- R7: A read or write strobe at pointer 1Fh steps the pointer to 00h and refreshes the snapshot. Loading 00h through `ptr_load` does not refresh it.
- R8: Some snapshot bits always read as 0: bit 7 of bytes 00h, 01h and 02h, and bits 7:3 of byte 03h. All other bits are copied unchanged. Byte i of `live_time` sits at bits 8i+7:8i.
- R9: A write to 00h–06h goes only to the write buffer and does not change what reads return. One cycle after a `bus_stop` edge, `set_load` is high for exactly one cycle if any time byte was written. At that point `set_mask` bit i marks byte i as written, and `set_time` byte i carries the written value.
- R10: Bytes 07h–0Fh read back the last value written to them.
- R11: Bytes 10h–1Fh read back the last value written to them. Start, stop and wrap refresh events leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Bus start condition strobe |
| bus_stop | input | 1 | Bus stop condition strobe |
| ptr_load | input | 1 | Load pointer from `ptr_val` |
| ptr_val | input | 5 | New pointer value |
| rd_strobe | input | 1 | Byte read consumed; advance pointer |
| wr_strobe | input | 1 | Byte write at pointer; advance pointer |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte at current pointer |
| live_time | input | 56 | Running time/date bytes from counter chain |
| set_load | output | 1 | One-cycle load pulse to counter chain |
| set_mask | output | 7 | Which time bytes were written |
| set_time | output | 56 | Buffered time bytes to load |

## Verification
Burst reads are run against a snapshot while `live_time` has already moved on. This shows whether reads come from the snapshot or leak through from the live bus. The snapshot is refreshed three separate ways: by start, by stop, and by a write burst that wraps past 1Fh. Each refresh is followed by a read that only the new value satisfies, so every trigger is checked on its own. Raw bytes with their unused bits set show up any missing mask. A partial two-byte time write is checked before and after stop to tell a buffered, masked commit apart from a direct write. Scratch and control bytes are read back after refresh events to show those events do not disturb them.

// File: rtl/tk_regs_pkg.sv
package tk_regs_pkg;
    localparam int ADDR_W    = 5;
    localparam int BYTE_W    = 8;
    localparam int NUM_TIME  = 7;
    localparam int CTL_BASE  = 7;
    localparam int NUM_CTL   = 9;
    localparam int SRAM_BASE = CTL_BASE + NUM_CTL;
    localparam int NUM_SRAM  = 16;
    localparam int NUM_STORE = NUM_CTL + NUM_SRAM;
    localparam int TIME_W    = NUM_TIME * BYTE_W;
    localparam int TIDX_W    = $clog2(NUM_TIME);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef byte_t [NUM_TIME-1:0] tbytes_t;

    typedef enum logic [1:0] {REG_TIME, REG_CTL, REG_SRAM} region_e;

    function automatic region_e region_of(addr_t a);
        if (a < addr_t'(CTL_BASE))       return REG_TIME;
        else if (a < addr_t'(SRAM_BASE)) return REG_CTL;
        else                             return REG_SRAM;
    endfunction

    // bits that exist in each time byte; the rest read as zero
    function automatic byte_t keep_bits(int unsigned idx);
        case (idx)
            0, 1, 2: return 8'h7F;
            3:       return 8'h07;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic tbytes_t clean_time(tbytes_t raw);
        tbytes_t res;
        for (int i = 0; i < NUM_TIME; i++) res[i] = raw[i] & keep_bits(i);
        return res;
    endfunction
endpackage

// File: rtl/tk_ptr.sv
module tk_ptr
    import tk_regs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld,
    input  addr_t ld_val,
    input  logic  step,
    output addr_t ptr,
    output logic  wrap
);
    assign wrap = step && !ld && (&ptr);

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (ld)   ptr <= ld_val;
        else if (step) ptr <= ptr + addr_t'(1);
    end
endmodule

// File: rtl/tk_snap.sv
module tk_snap
    import tk_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              refresh,
    input  tbytes_t           live,
    input  logic              wr_en,
    input  logic [TIDX_W-1:0] wr_idx,
    input  byte_t             wr_data,
    input  logic              commit,
    output tbytes_t           snap,
    output logic              set_load,
    output logic [NUM_TIME-1:0] set_mask,
    output tbytes_t           set_bytes
);
    tbytes_t             wbuf;
    logic [NUM_TIME-1:0] dirty;

    for (genvar g = 0; g < NUM_TIME; g++) begin : g_snap
        always_ff @(posedge clk) begin
            if (rst)          snap[g] <= '0;
            else if (refresh) snap[g] <= live[g] & keep_bits(g);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbuf      <= '0;
            dirty     <= '0;
            set_load  <= 1'b0;
            set_mask  <= '0;
            set_bytes <= '0;
        end else begin
            set_load <= 1'b0;
            if (commit) begin
                set_load  <= |dirty;
                set_mask  <= dirty;
                set_bytes <= wbuf;
                dirty     <= '0;
            end else if (wr_en) begin
                wbuf[wr_idx]  <= wr_data;
                dirty[wr_idx] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tk_store.sv
module tk_store
    import tk_regs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  addr_t wr_addr,
    input  byte_t wr_data,
    input  addr_t rd_addr,
    output byte_t rd_data
);
    byte_t mem [NUM_STORE];
    addr_t widx, ridx;

    assign widx = wr_addr - addr_t'(CTL_BASE);
    assign ridx = rd_addr - addr_t'(CTL_BASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_STORE; i++) mem[i] <= '0;
        end else if (wr_en && widx < addr_t'(NUM_STORE)) begin
            mem[widx] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (ridx < addr_t'(NUM_STORE)) rd_data = mem[ridx];
    end
endmodule

// File: rtl/tk_regfile.sv
module tk_regfile
    import tk_regs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_start,
    input  logic                bus_stop,
    input  logic                ptr_load,
    input  logic [ADDR_W-1:0]   ptr_val,
    input  logic                rd_strobe,
    input  logic                wr_strobe,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic [BYTE_W-1:0]   rd_data,
    input  logic [TIME_W-1:0]   live_time,
    output logic                set_load,
    output logic [NUM_TIME-1:0] set_mask,
    output logic [TIME_W-1:0]   set_time
);
    addr_t   ptr_q;
    logic    wrap;
    region_e region;
    tbytes_t live_b, snap_q, set_b;
    byte_t   store_rd;
    logic    refresh;

    assign live_b   = live_time;
    assign set_time = set_b;
    assign region   = region_of(ptr_q);
    assign refresh  = bus_start || bus_stop || wrap;

    tk_ptr u_ptr (
        .clk(clk), .rst(rst), .ld(ptr_load), .ld_val(ptr_val),
        .step(rd_strobe || wr_strobe), .ptr(ptr_q), .wrap(wrap)
    );

    tk_snap u_snap (
        .clk(clk), .rst(rst), .refresh(refresh), .live(live_b),
        .wr_en(wr_strobe && !ptr_load && region == REG_TIME),
        .wr_idx(ptr_q[TIDX_W-1:0]), .wr_data(wr_data), .commit(bus_stop),
        .snap(snap_q), .set_load(set_load), .set_mask(set_mask), .set_bytes(set_b)
    );

    tk_store u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr_strobe && !ptr_load && region != REG_TIME),
        .wr_addr(ptr_q), .wr_data(wr_data), .rd_addr(ptr_q), .rd_data(store_rd)
    );

    always_comb begin
        if (region == REG_TIME) rd_data = snap_q[ptr_q[TIDX_W-1:0]];
        else                    rd_data = store_rd;
    end
endmodule

// File: rtl/tk_regs_chk.sv
module tk_regs_chk
    import tk_regs_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    bus_start,
    input logic    bus_stop,
    input logic    ptr_load,
    input logic    rd_strobe,
    input logic    wr_strobe,
    input byte_t   rd_data,
    input addr_t   ptr,
    input tbytes_t snap,
    input tbytes_t live,
    input logic    set_load
);
    logic step_now, wrap_now;
    assign step_now = (rd_strobe || wr_strobe) && !ptr_load;
    assign wrap_now = step_now && ptr == addr_t'(2**ADDR_W - 1);

    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        step_now |=> ptr == $past(ptr) + addr_t'(1));

    a_r4_snapshot_holds: assert property (@(posedge clk) disable iff (rst)
        !(bus_start || bus_stop || wrap_now) |=> $stable(snap));

    a_r5_start_capture: assert property (@(posedge clk) disable iff (rst)
        bus_start |=> snap == clean_time($past(live)));

    a_r7_wrap_capture: assert property (@(posedge clk) disable iff (rst)
        wrap_now |=> (ptr == '0) && (snap == clean_time($past(live))));

    a_r8_top_bit_zero: assert property (@(posedge clk) disable iff (rst)
        (ptr < addr_t'(3)) |-> !rd_data[7]);

    a_r8_day_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (ptr == addr_t'(3)) |-> (rd_data[7:3] == 5'd0));

    a_r9_load_after_stop: assert property (@(posedge clk) disable iff (rst)
        set_load |-> $past(bus_stop));
endmodule

bind tk_regfile tk_regs_chk u_chk (
    .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
    .ptr_load(ptr_load), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .rd_data(rd_data), .ptr(ptr_q), .snap(snap_q), .live(live_b),
    .set_load(set_load)
);

// File: tb/tk_regfile_test.sv
module tk_regfile_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_start = 0, bus_stop = 0, ptr_load = 0, rd_strobe = 0, wr_strobe = 0;
    logic [4:0]  ptr_val = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [55:0] live_time = '0;
    logic        set_load;
    logic [6:0]  set_mask;
    logic [55:0] set_time;

    int total = 0;
    int bad   = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    tk_regfile uut (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
        .ptr_load(ptr_load), .ptr_val(ptr_val), .rd_strobe(rd_strobe),
        .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_data(rd_data),
        .live_time(live_time), .set_load(set_load), .set_mask(set_mask),
        .set_time(set_time)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compares each consumed read byte against the queued expectation
    always @(negedge clk) begin
        if (rd_strobe) begin
            if (exp_q.size() == 0) check("scoreboard-empty", 64'd1, 64'd0);
            else check(tag_q.pop_front(), {56'd0, rd_data}, {56'd0, exp_q.pop_front()});
        end
    end

    task automatic cyc(); @(posedge clk); #1; endtask
    task automatic do_start(); bus_start = 1; cyc(); bus_start = 0; endtask
    task automatic do_stop();  bus_stop = 1;  cyc(); bus_stop = 0;  endtask
    task automatic do_load(logic [4:0] a); ptr_load = 1; ptr_val = a; cyc(); ptr_load = 0; endtask
    task automatic do_read(logic [7:0] e, string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        rd_strobe = 1; cyc(); rd_strobe = 0;
    endtask
    task automatic do_write(logic [7:0] d); wr_strobe = 1; wr_data = d; cyc(); wr_strobe = 0; endtask
    task automatic set_live(logic [7:0] b [7]);
        for (int i = 0; i < 7; i++) live_time[8*i +: 8] = b[i];
    endtask

    function automatic logic [7:0] keep(int i, logic [7:0] v);
        if (i <= 2) return v & 8'h7F;
        if (i == 3) return v & 8'h07;
        return v;
    endfunction

    logic [7:0] lv1 [7] = '{8'hD9, 8'hB2, 8'hE3, 8'hFD, 8'h28, 8'h91, 8'h47};
    logic [7:0] lv2 [7] = '{8'h91, 8'h22, 8'h13, 8'h04, 8'h15, 8'h06, 8'h17};
    logic [7:0] lv3 [7] = '{8'h30, 8'h31, 8'h32, 8'h06, 8'h33, 8'h12, 8'h99};

    initial begin
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R1: reset state
        check("R1 set_load", {63'd0, set_load}, 64'd0);
        check("R1 rd_data at 00h", {56'd0, rd_data}, 64'd0);
        do_load(5'h07);
        do_read(8'h00, "R1 control byte");
        do_load(5'h1F);
        do_read(8'h00, "R1 scratch byte");
        // R5/R8: start captures masked live bytes; R2/R3 burst from 00h
        set_live(lv1);
        do_start();
        do_load(5'h00);
        for (int i = 0; i < 7; i++) do_read(keep(i, lv1[i]), "R5 R8 start snapshot");
        // R4/R7: live moves, pointer load to 00h, no refresh
        set_live(lv2);
        do_load(5'h00);
        for (int i = 0; i < 7; i++) do_read(keep(i, lv1[i]), "R4 R7 no refresh");
        // R6: stop refreshes
        do_stop();
        do_load(5'h00);
        for (int i = 0; i < 7; i++) do_read(keep(i, lv2[i]), "R6 stop snapshot");
        // R10/R11 writes; R3 auto-increment across 07h..1Fh, R7 wrap refresh
        do_load(5'h07);
        for (int i = 0; i < 9; i++) do_write(8'hA0 + 8'(i));
        for (int i = 0; i < 15; i++) do_write(8'h50 + 8'(i));
        set_live(lv3);
        do_write(8'h5F);
        for (int i = 0; i < 7; i++) do_read(keep(i, lv3[i]), "R7 wrap snapshot");
        do_load(5'h07);
        for (int i = 0; i < 9; i++) do_read(8'hA0 + 8'(i), "R10 control readback");
        for (int i = 0; i < 16; i++) do_read(8'h50 + 8'(i), "R11 scratch readback");
        // R9: buffered time write
        do_load(5'h01);
        do_write(8'h45);
        do_write(8'h12);
        do_load(5'h00);
        for (int i = 0; i < 3; i++) do_read(keep(i, lv3[i]), "R9 reads unaffected by write");
        check("R9 no load before stop", {63'd0, set_load}, 64'd0);
        do_stop();
        check("R9 load pulse", {63'd0, set_load}, 64'd1);
        check("R9 mask", {57'd0, set_mask}, 64'h06);
        check("R9 byte 01h", {56'd0, set_time[15:8]}, 64'h45);
        check("R9 byte 02h", {56'd0, set_time[23:16]}, 64'h12);
        cyc();
        check("R9 pulse one cycle", {63'd0, set_load}, 64'd0);
        do_stop();
        check("R9 no load without writes", {63'd0, set_load}, 64'd0);
        do_load(5'h10);
        do_read(8'h50, "R11 scratch after stop");
        do_load(5'h0F);
        do_read(8'hA8, "R10 status byte after stop");
        repeat (3) cyc();
        check("scoreboard drained", 64'(exp_q.size()), 64'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule